// File: doc/BRIEF.md
# Self-Timed Operation and Power-Mode Sequencer

This block sits behind the serial command front-end of a small flash memory. It decides which operating mode the device is in once a command has been accepted. The front-end reports each accepted command as a one-cycle strobe carrying a command kind. The sequencer holds the most recent one as pending and acts on it only when chip select returns high. Program, erase and status-write kinds then start a self-timed cycle. During that cycle the write-in-progress flag stays high for a parameterised number of ticks. When the cycle ends, the flag drops and a one-cycle pulse tells the status register to clear its write-enable latch.

Power-down is handled by the same block. A power-down command starts an entry delay and then puts the device into deep power-down. In that state every command except release is ignored. A release starts a wake-up delay. If the device is still in the entry delay, a release returns it to standby at once. Two gate outputs tell the front-end which commands may be accepted. Durations are counted in ticks of an external time base, so real microsecond and millisecond values scale to short simulations.

Top module: `op_timer_seq`

## Requirements
- R1: After reset the mode is standby (code 0), `wip` and `welClr` are 0, and both gates are 1.
- R2: Command kind codes are 1 status write, 2 page program, 3 sector erase, 4 block erase, 5 chip erase, 6 power-down, 7 release. A kind 1 to 5 accepted in standby starts a busy cycle (mode code 1, `wip` 1) on the clock after `csN` rises.
- R3: The busy cycle lasts exactly the kind's tick count, and `wip` goes low on the clock edge that samples the last tick.
- R4: `welClr` is high for exactly one cycle: the first cycle after a busy cycle ends. It is never high at any other time.
- R5: While busy, every strobe is ignored, including power-down and release, and the running cycle completes unchanged.
- R6: Power-down accepted in standby gives mode code 2 (entering) after `csN` rises. After `TDP_TICKS` ticks the mode becomes code 3 (deep power-down).
- R7: While entering, in deep power-down or while waking, every kind other than release is ignored. While waking, release is ignored as well.
- R8: Release in deep power-down gives mode code 4 (waking) after `csN` rises. After `TRES_TICKS` ticks the mode returns to standby.
- R9: Release in standby, or while entering, leaves the device in standby on the clock after `csN` rises.
- R10: `gateAll` is 1 only in standby. `gateRelease` is 1 in standby, entering and deep power-down, and 0 while busy or waking.
- R11: A pending command does nothing while `csN` stays low. Nothing starts before `csN` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip-select level, synchronised, low while selected |
| tick | input | 1 | Time-base enable; each high cycle is one tick |
| cmdStb | input | 1 | One-cycle strobe for an accepted command |
| cmdKind | input | 3 | Kind of the strobed command (codes in R2) |
| wip | output | 1 | Write in progress |
| welClr | output | 1 | One-cycle pulse that clears the write-enable latch |
| mode | output | 3 | Mode: 0 standby, 1 busy, 2 entering, 3 deep power-down, 4 waking |
| gateAll | output | 1 | Front-end may accept any command |
| gateRelease | output | 1 | Front-end may accept a release command |

## Verification
The embedded properties take the following for granted:
- `csN` arrives already synchronised.
- Strobes occur only while `csN` is low.
- Each tick count parameter is at least 1.

The stimulus keeps within these rules. Random frames lower `csN`, may place one strobe of any kind inside the frame, and raise `csN` again. The tick input is randomised between frames. Directed cases freeze the tick so that a command can land inside the entry delay or the wake-up delay. The directed cases also measure each mode's length in cycles while ticking continuously.

// File: rtl/ptseq_pkg.sv
package ptseq_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_WRSR = 3'd1,
    OP_PP   = 3'd2,
    OP_SE   = 3'd3,
    OP_BE   = 3'd4,
    OP_CE   = 3'd5,
    OP_DP   = 3'd6,
    OP_RDP  = 3'd7
  } opKind_t;

  typedef enum logic [2:0] {
    MD_STANDBY = 3'd0,
    MD_BUSY    = 3'd1,
    MD_ENTER   = 3'd2,
    MD_DPD     = 3'd3,
    MD_WAKE    = 3'd4
  } mode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    capture;
    logic    clearPend;
    logic    loadTimer;
    opKind_t loadKind;
  } seqCtl_t;

endpackage

// File: rtl/ptseq_dp.sv
module ptseq_dp
  import ptseq_pkg::*;
#(
  parameter int CNT_W      = 20,
  parameter int TW_TICKS   = 5000,
  parameter int TPP_TICKS  = 180,
  parameter int TSE_TICKS  = 90000,
  parameter int TBE_TICKS  = 1000000,
  parameter int TCE_TICKS  = 1000000,
  parameter int TDP_TICKS  = 20,
  parameter int TRES_TICKS = 20
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    csN,
  input  logic    tick,
  input  opKind_t cmdKind,
  input  seqCtl_t ctl,
  output logic    csRise,
  output opKind_t pendKind,
  output logic    timerDone
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             csPrev;
  opKind_t          pendQ;
  logic [CNT_W-1:0] cnt;

  function automatic logic [CNT_W-1:0] loadVal(opKind_t k);
    case (k)
      OP_WRSR: return CNT_W'(TW_TICKS);
      OP_PP:   return CNT_W'(TPP_TICKS);
      OP_SE:   return CNT_W'(TSE_TICKS);
      OP_BE:   return CNT_W'(TBE_TICKS);
      OP_CE:   return CNT_W'(TCE_TICKS);
      OP_DP:   return CNT_W'(TDP_TICKS);
      OP_RDP:  return CNT_W'(TRES_TICKS);
      default: return '0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) csPrev <= 1'b1;
    else       csPrev <= csN;
  end

  assign csRise = csN & ~csPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pendQ <= OP_NONE;
    else if (ctl.clearPend) pendQ <= OP_NONE;
    else if (ctl.capture)   pendQ <= cmdKind;
  end

  assign pendKind = pendQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   cnt <= '0;
    else if (ctl.loadTimer)      cnt <= loadVal(ctl.loadKind);
    else if (tick && cnt != '0)  cnt <= cnt - CNT_ONE;
  end

  assign timerDone = tick && (cnt == CNT_ONE);

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.loadTimer) |=> (cnt == $past(cnt) || cnt == $past(cnt) - CNT_ONE));

  // R3
  done_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timerDone && !ctl.loadTimer) |=> (cnt == '0));

endmodule

// File: rtl/ptseq_ctrl.sv
module ptseq_ctrl
  import ptseq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    csN,
  input  logic    cmdStb,
  input  opKind_t cmdKind,
  input  logic    csRise,
  input  opKind_t pendKind,
  input  logic    timerDone,
  output seqCtl_t ctl,
  output mode_t   modeQ,
  output logic    welClrQ
);

  mode_t stQ, stD;
  logic  welD;

  always_comb begin
    ctl  = '0;
    stD  = stQ;
    welD = 1'b0;

    if (cmdStb && !csN && cmdKind != OP_NONE) begin
      if (stQ == MD_STANDBY)
        ctl.capture = 1'b1;
      else if ((stQ == MD_ENTER || stQ == MD_DPD) && cmdKind == OP_RDP)
        ctl.capture = 1'b1;
    end

    if (csRise && pendKind != OP_NONE) begin
      ctl.clearPend = 1'b1;
      case (stQ)
        MD_STANDBY: begin
          if (pendKind inside {OP_WRSR, OP_PP, OP_SE, OP_BE, OP_CE}) begin
            stD          = MD_BUSY;
            ctl.loadTimer = 1'b1;
            ctl.loadKind  = pendKind;
          end else if (pendKind == OP_DP) begin
            stD          = MD_ENTER;
            ctl.loadTimer = 1'b1;
            ctl.loadKind  = OP_DP;
          end
        end
        MD_ENTER: begin
          if (pendKind == OP_RDP) begin
            stD          = MD_STANDBY;
            ctl.loadTimer = 1'b1;
            ctl.loadKind  = OP_NONE;
          end
        end
        MD_DPD: begin
          if (pendKind == OP_RDP) begin
            stD          = MD_WAKE;
            ctl.loadTimer = 1'b1;
            ctl.loadKind  = OP_RDP;
          end
        end
        default: ;
      endcase
    end else if (timerDone) begin
      case (stQ)
        MD_BUSY: begin
          stD  = MD_STANDBY;
          welD = 1'b1;
        end
        MD_ENTER: stD = MD_DPD;
        MD_WAKE:  stD = MD_STANDBY;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ     <= MD_STANDBY;
      welClrQ <= 1'b0;
    end else begin
      stQ     <= stD;
      welClrQ <= welD;
    end
  end

  assign modeQ = stQ;

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == MD_STANDBY && csRise && (pendKind inside {OP_WRSR, OP_PP, OP_SE, OP_BE, OP_CE}))
    |=> (stQ == MD_BUSY));

  // R4
  welclr_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    welClrQ |-> ($past(stQ) == MD_BUSY && stQ == MD_STANDBY));

  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == MD_BUSY && !timerDone) |=> (stQ == MD_BUSY));

  // R8
  dpd_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == MD_DPD) |=> (stQ == MD_DPD || stQ == MD_WAKE));

endmodule

// File: rtl/op_timer_seq.sv
module op_timer_seq
  import ptseq_pkg::*;
#(
  parameter int CNT_W      = 20,
  parameter int TW_TICKS   = 5000,
  parameter int TPP_TICKS  = 180,
  parameter int TSE_TICKS  = 90000,
  parameter int TBE_TICKS  = 1000000,
  parameter int TCE_TICKS  = 1000000,
  parameter int TDP_TICKS  = 20,
  parameter int TRES_TICKS = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       tick,
  input  logic       cmdStb,
  input  logic [2:0] cmdKind,
  output logic       wip,
  output logic       welClr,
  output logic [2:0] mode,
  output logic       gateAll,
  output logic       gateRelease
);

  opKind_t kindIn;
  seqCtl_t ctl;
  logic    csRise;
  opKind_t pendKind;
  logic    timerDone;
  mode_t   modeQ;

  assign kindIn = opKind_t'(cmdKind);

  ptseq_dp #(
    .CNT_W(CNT_W), .TW_TICKS(TW_TICKS), .TPP_TICKS(TPP_TICKS),
    .TSE_TICKS(TSE_TICKS), .TBE_TICKS(TBE_TICKS), .TCE_TICKS(TCE_TICKS),
    .TDP_TICKS(TDP_TICKS), .TRES_TICKS(TRES_TICKS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .csN(csN), .tick(tick), .cmdKind(kindIn),
    .ctl(ctl), .csRise(csRise), .pendKind(pendKind), .timerDone(timerDone)
  );

  ptseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .cmdStb(cmdStb), .cmdKind(kindIn),
    .csRise(csRise), .pendKind(pendKind), .timerDone(timerDone),
    .ctl(ctl), .modeQ(modeQ), .welClrQ(welClr)
  );

  assign mode        = modeQ;
  assign wip         = (modeQ == MD_BUSY);
  assign gateAll     = (modeQ == MD_STANDBY);
  assign gateRelease = (modeQ == MD_STANDBY) || (modeQ == MD_ENTER) || (modeQ == MD_DPD);

  // R10
  gate_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    gateAll |-> gateRelease);

endmodule

// File: tb/op_timer_seq_bench.sv
module op_timer_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int P_TW = 7, P_TPP = 4, P_TSE = 9, P_TBE = 12, P_TCE = 15;
  localparam int P_TDP = 3, P_TRES = 5;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, tick = 1'b0, cmdStb = 1'b0;
  logic [2:0] cmdKind = 3'd0;
  logic wip, welClr, gateAll, gateRelease;
  logic [2:0] mode;

  op_timer_seq #(
    .CNT_W(16), .TW_TICKS(P_TW), .TPP_TICKS(P_TPP), .TSE_TICKS(P_TSE),
    .TBE_TICKS(P_TBE), .TCE_TICKS(P_TCE), .TDP_TICKS(P_TDP), .TRES_TICKS(P_TRES)
  ) u_op_timer_seq (
    .clk(clk), .rstN(rstN), .csN(csN), .tick(tick), .cmdStb(cmdStb),
    .cmdKind(cmdKind), .wip(wip), .welClr(welClr), .mode(mode),
    .gateAll(gateAll), .gateRelease(gateRelease)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  string curTag = "R1";
  bit finished = 0;
  bit randTick = 0;

  function automatic int durOf(int k);
    case (k)
      1: return P_TW;
      2: return P_TPP;
      3: return P_TSE;
      4: return P_TBE;
      5: return P_TCE;
      6: return P_TDP;
      7: return P_TRES;
      default: return 0;
    endcase
  endfunction

  function automatic string modeTag(int m);
    case (m)
      1: return "R3";
      2: return "R6";
      3: return "R7";
      4: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // reference model, stepped from the requirements
  int mMode, mPend, mTicks, mTarget;
  bit mCsPrev, mWel;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMode = 0; mPend = 0; mTicks = 0; mTarget = 0; mCsPrev = 1; mWel = 0;
    end else begin : step
      int nMode, nPend;
      bit nWel, rise;
      nMode = mMode; nPend = mPend; nWel = 0;
      rise = csN && !mCsPrev;
      if (cmdStb && !csN && cmdKind != 3'd0) begin
        if (mMode == 0) nPend = int'(cmdKind);
        else if ((mMode == 2 || mMode == 3) && cmdKind == 3'd7) nPend = 7;
      end
      if (rise && mPend != 0) begin
        nPend = 0;
        if (mMode == 0 && mPend <= 5) begin
          nMode = 1; mTarget = durOf(mPend); mTicks = 0;
        end else if (mMode == 0 && mPend == 6) begin
          nMode = 2; mTarget = P_TDP; mTicks = 0;
        end else if (mMode == 2 && mPend == 7) begin
          nMode = 0;
        end else if (mMode == 3 && mPend == 7) begin
          nMode = 4; mTarget = P_TRES; mTicks = 0;
        end
      end else if ((mMode == 1 || mMode == 2 || mMode == 4) && tick) begin
        mTicks++;
        if (mTicks == mTarget) begin
          if (mMode == 1) begin nMode = 0; nWel = 1; end
          else if (mMode == 2) nMode = 3;
          else nMode = 0;
        end
      end
      mMode = nMode; mPend = nPend; mWel = nWel; mCsPrev = csN;
    end
  end

  always @(negedge clk) begin
    if (!finished && rstN) begin
      chk(curTag == "R2" ? modeTag(mMode) : curTag, "mode", int'(mode), mMode);
      chk("R3", "wip", int'(wip), (mMode == 1) ? 1 : 0);
      chk("R4", "welClr", int'(welClr), int'(mWel));
      chk("R10", "gateAll", int'(gateAll), (mMode == 0) ? 1 : 0);
      chk("R10", "gateRelease", int'(gateRelease),
          (mMode == 0 || mMode == 2 || mMode == 3) ? 1 : 0);
    end
  end

  always @(negedge clk) if (randTick) tick = ($urandom % 4) != 0;

  task automatic frame(int kind, int pre);
    @(negedge clk); csN = 1'b0;
    repeat (pre) @(negedge clk);
    cmdStb = 1'b1; cmdKind = 3'(kind);
    @(negedge clk); cmdStb = 1'b0; cmdKind = 3'd0;
    @(negedge clk); csN = 1'b1;
  endtask

  // counts cycles spent in mode m; call right after frame()
  task automatic measure(int m, output int n);
    n = 0;
    @(negedge clk);
    while (int'(mode) == m && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic waitIdle();
    int guard = 0;
    while (mode != 3'd0 && guard < 2000) begin
      @(negedge clk); guard++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int n;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk("R1", "reset mode", int'(mode), 0);
    chk("R1", "reset wip", int'(wip), 0);
    chk("R1", "reset welClr", int'(welClr), 0);
    chk("R1", "reset gates", int'({gateAll, gateRelease}), 3);
    rstN = 1'b1;
    tick = 1'b1;
    repeat (2) @(negedge clk);

    // R2, R3, R4: each self-timed kind
    curTag = "R2";
    for (int k = 1; k <= 5; k++) begin
      frame(k, 1);
      measure(1, n);
      chk("R3", $sformatf("busy length kind %0d", k), n, durOf(k));
      chk("R4", "welClr after busy", int'(welClr), 1);
      @(negedge clk);
      chk("R4", "welClr one cycle", int'(welClr), 0);
    end

    // R11: nothing starts while csN stays low
    curTag = "R11";
    @(negedge clk); csN = 1'b0;
    cmdStb = 1'b1; cmdKind = 3'd2;
    @(negedge clk); cmdStb = 1'b0; cmdKind = 3'd0;
    repeat (10) @(negedge clk);
    chk("R11", "mode with csN low", int'(mode), 0);
    csN = 1'b1;
    @(negedge clk);
    chk("R11", "busy after csN rise", int'(mode), 1);
    waitIdle();

    // R5: power-down and release ignored while busy
    curTag = "R5";
    frame(3, 0);
    frame(6, 0);
    frame(7, 0);
    waitIdle();
    @(negedge clk);
    chk("R5", "no power-down after busy", int'(mode), 0);

    // R6: entry delay then deep power-down
    curTag = "R6";
    frame(6, 1);
    measure(2, n);
    chk("R6", "entry length", n, P_TDP);
    chk("R6", "in deep power-down", int'(mode), 3);

    // R7: other kinds ignored in deep power-down
    curTag = "R7";
    frame(2, 0);
    frame(6, 0);
    repeat (5) @(negedge clk);
    chk("R7", "still powered down", int'(mode), 3);

    // R8: release with wake-up delay
    curTag = "R8";
    frame(7, 0);
    measure(4, n);
    chk("R8", "wake length", n, P_TRES);
    chk("R8", "standby after wake", int'(mode), 0);

    // R7: commands during wake-up ignored
    curTag = "R7";
    frame(6, 0); waitIdle(); @(negedge clk);
    frame(6, 0); @(negedge clk); waitIdle();
    frame(6, 1); repeat (P_TDP + 2) @(negedge clk);
    tick = 1'b0;
    frame(7, 0);
    @(negedge clk);
    chk("R7", "waking held", int'(mode), 4);
    frame(2, 0);
    tick = 1'b1;
    waitIdle();
    repeat (3) @(negedge clk);
    chk("R7", "no busy after wake", int'(mode), 0);

    // R9: release when not powered down
    curTag = "R9";
    frame(7, 0);
    @(negedge clk);
    chk("R9", "release in standby", int'(mode), 0);
    tick = 1'b0;
    frame(6, 0);
    @(negedge clk);
    chk("R9", "entering held", int'(mode), 2);
    frame(7, 0);
    @(negedge clk);
    chk("R9", "release while entering", int'(mode), 0);
    tick = 1'b1;
    repeat (P_TDP + 2) @(negedge clk);
    chk("R9", "stays standby", int'(mode), 0);

    // random frames
    curTag = "R2";
    randTick = 1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk); csN = 1'b0;
      repeat ($urandom % 4) @(negedge clk);
      if (($urandom % 5) != 0) begin
        cmdStb = 1'b1; cmdKind = 3'($urandom % 8);
        @(negedge clk); cmdStb = 1'b0; cmdKind = 3'd0;
      end
      repeat ($urandom % 3) @(negedge clk);
      csN = 1'b1;
      repeat ($urandom % 20) @(negedge clk);
    end
    randTick = 0;
    tick = 1'b1;
    repeat (40) @(negedge clk);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule